// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

This block picks, separately for each processor in a small cluster, the most urgent interrupt out of a shared table of sources. Every source carries one priority value, shared by all processors. Each processor has its own enable and pending bit for every source. A source competes for a given processor only when both of that processor's bits are set. A smaller priority number means a more urgent interrupt. The winning priority is then compared with the processor's priority mask and with the priority of the handler it is already running. From this the block produces a highest-pending identifier and an interrupt request line for each processor.

The surrounding interrupt controller keeps all the state and presents it as inputs: the table, the masks, the running priorities and the enables. Register access, acknowledge, completion and the setting of pending bits all happen outside this block. The arbitration is purely combinational over those inputs, and the two outputs for each processor are registered once per clock. The identifier 1023 is reserved to mean that no interrupt is presented.

Top module: `irq_prio_arbiter`

## Requirements
- R1: For each CPU, only sources whose enable and pending bits for that CPU are both 1 compete. Among them the one with the numerically smallest priority wins.
- R2: When two or more competing sources share the smallest priority, the one with the lowest source ID wins.
- R3: When a CPU has no competing source, its `hp_id` is 1023 and its `irq_req` is 0.
- R4: A winner's ID appears on `hp_id` only when its priority is strictly less than that CPU's 8-bit priority mask. A priority equal to or above the mask gives 1023 and a low request.
- R5: `irq_req` is 1 only when the winner is unmasked and its priority is also strictly less than that CPU's running priority. An unmasked winner's ID is still shown when the request stays low.
- R6: When `dist_en` is 0, every CPU shows `hp_id` = 1023 and `irq_req` = 0. When `cpu_if_en[c]` is 0, CPU c alone shows 1023 and 0.
- R7: A running priority of 0x100 (the idle value, one above every real priority) lets any unmasked winner raise the request, including priority 0xFE under mask 0xFF.
- R8: Both outputs are registered. A change on the inputs appears on the outputs after the next rising clock edge. While reset is asserted, every `hp_id` is 1023 and every `irq_req` is 0.
- R9: Each CPU's result depends only on the shared priority table, the global enable and that CPU's own enable, pending, mask, running priority and interface enable.
- R10: The linear-scan arbitration variant and the reduction-tree variant give identical results for all inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dist_en | input | 1 | Global enable for the whole distributor |
| cpu_if_en | input | NUM_CPU | Interface enable for each CPU |
| src_prio | input | NUM_SRC*PRIO_W | Priority of source i at bits [i*PRIO_W +: PRIO_W] |
| src_pend | input | NUM_CPU*NUM_SRC | Pending bit of source i for CPU c at bit c*NUM_SRC+i |
| src_enab | input | NUM_CPU*NUM_SRC | Enable bit of source i for CPU c at bit c*NUM_SRC+i |
| cpu_pmask | input | NUM_CPU*PRIO_W | Priority mask of CPU c at bits [c*PRIO_W +: PRIO_W] |
| cpu_run_prio | input | NUM_CPU*(PRIO_W+1) | Running priority of CPU c at bits [c*(PRIO_W+1) +: PRIO_W+1]; 0x100 means idle |
| hp_id | output | NUM_CPU*10 | Highest-pending ID of CPU c at bits [c*10 +: 10]; 1023 means none |
| irq_req | output | NUM_CPU | Interrupt request line for each CPU |

## Verification
The bench builds two copies of the block. The first uses the defaults: 64 sources, 4 CPUs and the reduction tree, which is a full power-of-two tree with no padding. The second uses 37 sources, 2 CPUs and the linear scan, so its tree would need padded leaves and its top source sits at an odd position. Both copies are driven from one shared state and compared with a single reference scan. Directed cases reach ties across subtree boundaries, the exact-equal edges of the mask and the running priority, and the idle running value. A long random run then compares the two variants against each other through the reference.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   // Identifier width is fixed: the value 1023 is reserved as "none".
   localparam int unsigned IRQ_ID_W = 10;
   localparam logic [IRQ_ID_W-1:0] IRQ_NONE = 10'd1023;

   typedef enum logic [0:0] {
      ARB_LINEAR = 1'b0,
      ARB_TREE   = 1'b1
   } arb_style_e;

endpackage

// File: rtl/irq_arb_select.sv
// Finds the most urgent competing source; lowest ID wins on equal priority.
module irq_arb_select
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 64,
   parameter int unsigned PRIO_W    = 8,
   parameter arb_style_e  ARB_STYLE = ARB_TREE
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_SRC-1:0]                cand,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0]    prio,
   output logic [PRIO_W:0]                   best_prio,
   output logic [IRQ_ID_W-1:0]               best_id
);

   localparam logic [PRIO_W:0] IDLE_PRIO = (PRIO_W+1)'(1) << PRIO_W;

   if (ARB_STYLE == ARB_LINEAR) begin : g_linear
      always_comb begin
         best_prio = IDLE_PRIO;
         best_id   = IRQ_NONE;
         for (int i = 0; i < int'(NUM_SRC); i++) begin
            if (cand[i] && ({1'b0, prio[i]} < best_prio)) begin
               best_prio = {1'b0, prio[i]};
               best_id   = IRQ_ID_W'(i);
            end
         end
      end
   end else begin : g_tree
      localparam int unsigned LVL    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
      localparam int unsigned LEAVES = 1 << LVL;
      localparam int unsigned NODES  = 2 * LEAVES - 1;

      logic [NODES-1:0][PRIO_W:0]     node_prio;
      logic [NODES-1:0][IRQ_ID_W-1:0] node_id;

      for (genvar i = 0; i < int'(LEAVES); i++) begin : g_leaf
         if (i < int'(NUM_SRC)) begin : g_real
            assign node_prio[LEAVES-1+i] = cand[i] ? {1'b0, prio[i]} : IDLE_PRIO;
            assign node_id[LEAVES-1+i]   = cand[i] ? IRQ_ID_W'(i) : IRQ_NONE;
         end else begin : g_pad
            assign node_prio[LEAVES-1+i] = IDLE_PRIO;
            assign node_id[LEAVES-1+i]   = IRQ_NONE;
         end
      end

      // Left subtree holds the lower IDs, so it keeps ties.
      for (genvar k = 0; k < int'(LEAVES) - 1; k++) begin : g_node
         logic take_right;
         assign take_right   = node_prio[2*k+2] < node_prio[2*k+1];
         assign node_prio[k] = take_right ? node_prio[2*k+2] : node_prio[2*k+1];
         assign node_id[k]   = take_right ? node_id[2*k+2]   : node_id[2*k+1];
      end

      assign best_prio = node_prio[0];
      assign best_id   = node_id[0];
   end

   AST_WINNER_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (best_id != IRQ_NONE) |-> ((32'(best_id) < NUM_SRC) && cand[best_id]
                                 && (best_prio == {1'b0, prio[best_id]}))); // R1

   AST_EMPTY_GIVES_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cand == '0) |-> ((best_id == IRQ_NONE) && (best_prio == IDLE_PRIO))); // R3

endmodule

// File: rtl/irq_arb_judge.sv
// Applies the gates, the priority mask and the running priority to a winner.
module irq_arb_judge
   import irq_arb_pkg::*;
#(
   parameter int unsigned PRIO_W = 8
) (
   input  logic                gate_on,
   input  logic [PRIO_W:0]     best_prio,
   input  logic [IRQ_ID_W-1:0] best_id,
   input  logic [PRIO_W-1:0]   pmask,
   input  logic [PRIO_W:0]     run_prio,
   output logic [IRQ_ID_W-1:0] nxt_id,
   output logic                nxt_req
);

   logic unmasked;
   logic preempts;

   assign unmasked = gate_on && (best_prio < {1'b0, pmask});
   assign preempts = best_prio < run_prio;
   assign nxt_id   = unmasked ? best_id : IRQ_NONE;
   assign nxt_req  = unmasked && preempts;

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 64,
   parameter int unsigned NUM_CPU   = 4,
   parameter int unsigned PRIO_W    = 8,
   parameter arb_style_e  ARB_STYLE = ARB_TREE
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            dist_en,
   input  logic [NUM_CPU-1:0]              cpu_if_en,
   input  logic [NUM_SRC*PRIO_W-1:0]       src_prio,
   input  logic [NUM_CPU*NUM_SRC-1:0]      src_pend,
   input  logic [NUM_CPU*NUM_SRC-1:0]      src_enab,
   input  logic [NUM_CPU*PRIO_W-1:0]       cpu_pmask,
   input  logic [NUM_CPU*(PRIO_W+1)-1:0]   cpu_run_prio,
   output logic [NUM_CPU*IRQ_ID_W-1:0]     hp_id,
   output logic [NUM_CPU-1:0]              irq_req
);

   localparam int unsigned RUN_W = PRIO_W + 1;

   if (NUM_SRC < 1 || NUM_SRC > 1020) begin : g_chk_src
      $error("irq_prio_arbiter: NUM_SRC must be 1..1020");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_chk_cpu
      $error("irq_prio_arbiter: NUM_CPU must be 1..8");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_chk_prio
      $error("irq_prio_arbiter: PRIO_W must be 1..8");
   end

   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_tab;
   for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_tab
      assign prio_tab[i] = src_prio[i*PRIO_W +: PRIO_W];
   end

   logic [NUM_CPU-1:0][IRQ_ID_W-1:0] id_q;
   logic [NUM_CPU-1:0]               req_q;

   for (genvar c = 0; c < int'(NUM_CPU); c++) begin : g_cpu
      logic [NUM_SRC-1:0]  cand;
      logic [PRIO_W:0]     best_prio;
      logic [IRQ_ID_W-1:0] best_id;
      logic [IRQ_ID_W-1:0] nxt_id;
      logic                nxt_req;
      logic                gate_on;

      assign cand    = src_pend[c*NUM_SRC +: NUM_SRC] & src_enab[c*NUM_SRC +: NUM_SRC];
      assign gate_on = dist_en && cpu_if_en[c];

      irq_arb_select #(
         .NUM_SRC   (NUM_SRC),
         .PRIO_W    (PRIO_W),
         .ARB_STYLE (ARB_STYLE)
      ) u_sel (
         .clk       (clk),
         .rst_n     (rst_n),
         .cand      (cand),
         .prio      (prio_tab),
         .best_prio (best_prio),
         .best_id   (best_id)
      );

      irq_arb_judge #(
         .PRIO_W    (PRIO_W)
      ) u_judge (
         .gate_on   (gate_on),
         .best_prio (best_prio),
         .best_id   (best_id),
         .pmask     (cpu_pmask[c*PRIO_W +: PRIO_W]),
         .run_prio  (cpu_run_prio[c*RUN_W +: RUN_W]),
         .nxt_id    (nxt_id),
         .nxt_req   (nxt_req)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            id_q[c]  <= IRQ_NONE;
            req_q[c] <= 1'b0;
         end else begin
            id_q[c]  <= nxt_id;
            req_q[c] <= nxt_req;
         end
      end

      assign hp_id[c*IRQ_ID_W +: IRQ_ID_W] = id_q[c];
      assign irq_req[c]                    = req_q[c];

      AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         (!dist_en || !cpu_if_en[c]) |=> (!irq_req[c] && (hp_id[c*IRQ_ID_W +: IRQ_ID_W] == IRQ_NONE))); // R6

      AST_REQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
         irq_req[c] |-> (hp_id[c*IRQ_ID_W +: IRQ_ID_W] != IRQ_NONE)); // R5

      AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (hp_id[c*IRQ_ID_W +: IRQ_ID_W] == IRQ_NONE)
         || (32'(hp_id[c*IRQ_ID_W +: IRQ_ID_W]) < NUM_SRC)); // R4

      AST_REQ_BELOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
         (best_prio >= cpu_run_prio[c*RUN_W +: RUN_W]) |=> !irq_req[c]); // R5
   end

endmodule

// File: tb/irq_prio_arbiter_bench.sv
`timescale 1ns/1ps
module irq_prio_arbiter_bench;
   import irq_arb_pkg::*;

   localparam int NA = 64, CA = 4;   // copy A: tree, defaults
   localparam int NB = 37, CB = 2;   // copy B: linear scan
   localparam int CLK_NS = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Shared stimulus state.
   bit [7:0] t_prio [NA];
   bit       t_pend [CA][NA];
   bit       t_en   [CA][NA];
   bit [7:0] t_mask [CA];
   bit [8:0] t_run  [CA];
   bit       t_den;
   bit       t_cen  [CA];

   logic [NA*8-1:0]   a_prio;
   logic [CA*NA-1:0]  a_pend, a_en;
   logic [CA*8-1:0]   a_mask;
   logic [CA*9-1:0]   a_run;
   logic [CA-1:0]     a_cen;
   logic [CA*10-1:0]  a_id;
   logic [CA-1:0]     a_req;

   logic [NB*8-1:0]   b_prio;
   logic [CB*NB-1:0]  b_pend, b_en;
   logic [CB*8-1:0]   b_mask;
   logic [CB*9-1:0]   b_run;
   logic [CB-1:0]     b_cen;
   logic [CB*10-1:0]  b_id;
   logic [CB-1:0]     b_req;

   always_comb begin
      for (int i = 0; i < NA; i++) a_prio[i*8 +: 8] = t_prio[i];
      for (int c = 0; c < CA; c++) begin
         for (int i = 0; i < NA; i++) begin
            a_pend[c*NA+i] = t_pend[c][i];
            a_en[c*NA+i]   = t_en[c][i];
         end
         a_mask[c*8 +: 8] = t_mask[c];
         a_run[c*9 +: 9]  = t_run[c];
         a_cen[c]         = t_cen[c];
      end
      for (int i = 0; i < NB; i++) b_prio[i*8 +: 8] = t_prio[i];
      for (int c = 0; c < CB; c++) begin
         for (int i = 0; i < NB; i++) begin
            b_pend[c*NB+i] = t_pend[c][i];
            b_en[c*NB+i]   = t_en[c][i];
         end
         b_mask[c*8 +: 8] = t_mask[c];
         b_run[c*9 +: 9]  = t_run[c];
         b_cen[c]         = t_cen[c];
      end
   end

   irq_prio_arbiter u_irq_prio_arbiter (
      .clk(clk), .rst_n(rst_n), .dist_en(t_den), .cpu_if_en(a_cen),
      .src_prio(a_prio), .src_pend(a_pend), .src_enab(a_en),
      .cpu_pmask(a_mask), .cpu_run_prio(a_run), .hp_id(a_id), .irq_req(a_req));

   irq_prio_arbiter #(.NUM_SRC(NB), .NUM_CPU(CB), .PRIO_W(8), .ARB_STYLE(ARB_LINEAR)) u_irq_prio_arbiter_lin (
      .clk(clk), .rst_n(rst_n), .dist_en(t_den), .cpu_if_en(b_cen),
      .src_prio(b_prio), .src_pend(b_pend), .src_enab(b_en),
      .cpu_pmask(b_mask), .cpu_run_prio(b_run), .hp_id(b_id), .irq_req(b_req));

   // Reference scan built from the requirements.
   function automatic void ref_scan(input int c, input int nsrc, output int id, output bit req);
      int best = 256;
      int bid  = 1023;
      for (int i = 0; i < nsrc; i++)
         if (t_pend[c][i] && t_en[c][i] && int'(t_prio[i]) < best) begin
            best = int'(t_prio[i]);
            bid  = i;
         end
      if (!t_den || !t_cen[c] || best >= int'(t_mask[c])) begin
         id = 1023; req = 1'b0;
      end else begin
         id = bid; req = (best < int'(t_run[c]));
      end
   endfunction

   task automatic check_one(input string tag, input int dut, input int c,
                            input int got_id, input bit got_req, input int exp_id, input bit exp_req);
      n_tests++;
      if (got_id != exp_id || got_req != exp_req) begin
         n_fail++;
         $display("FAIL %s dut%0d cpu%0d: id=%0d req=%0d, expected id=%0d req=%0d",
                  tag, dut, c, got_id, got_req, exp_id, exp_req);
      end
   endtask

   task automatic check_all(input string tag);
      int eid; bit ereq;
      for (int c = 0; c < CA; c++) begin
         ref_scan(c, NA, eid, ereq);
         check_one(tag, 0, c, int'(a_id[c*10 +: 10]), a_req[c], eid, ereq);
      end
      for (int c = 0; c < CB; c++) begin
         ref_scan(c, NB, eid, ereq);
         check_one(tag, 1, c, int'(b_id[c*10 +: 10]), b_req[c], eid, ereq);
      end
   endtask

   // Inputs change at a falling edge; results are read one clock later.
   task automatic settle(input string tag);
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic clear_state();
      for (int i = 0; i < NA; i++) t_prio[i] = 8'hC0;
      for (int c = 0; c < CA; c++) begin
         for (int i = 0; i < NA; i++) begin t_pend[c][i] = 0; t_en[c][i] = 0; end
         t_mask[c] = 8'hFF; t_run[c] = 9'h100; t_cen[c] = 1'b1;
      end
      t_den = 1'b1;
   endtask

   task automatic make_cand(input int c, input int i, input bit [7:0] p);
      t_pend[c][i] = 1; t_en[c][i] = 1; t_prio[i] = p;
   endtask

   task automatic t_reset();
      clear_state();
      make_cand(0, 3, 8'h10);
      #(CLK_NS*3);
      @(negedge clk);
      for (int c = 0; c < CA; c++)
         check_one("R8 reset", 0, c, int'(a_id[c*10 +: 10]), a_req[c], 1023, 0);
      rst_n = 1'b1;
      settle("R8 after reset");
   endtask

   task automatic t_urgency();
      @(negedge clk); clear_state();
      make_cand(0, 5, 8'h40);
      make_cand(0, 9, 8'h20);
      t_pend[0][3] = 1; t_prio[3] = 8'h10;         // pending but disabled
      t_en[0][4] = 1;   t_prio[4] = 8'h08;         // enabled but not pending
      settle("R1 urgency");
      check_one("R1 explicit", 0, 0, int'(a_id[9:0]), a_req[0], 9, 1);
   endtask

   task automatic t_tie();
      @(negedge clk); clear_state();
      make_cand(0, 20, 8'h30);
      make_cand(0, 7, 8'h30);
      make_cand(1, 36, 8'h30);
      make_cand(1, 31, 8'h30);
      make_cand(2, 63, 8'h30);
      make_cand(2, 32, 8'h30);
      settle("R2 tie");
      check_one("R2 explicit", 0, 2, int'(a_id[29:20]), a_req[2], 32, 1);
   endtask

   task automatic t_empty();
      @(negedge clk); clear_state();
      t_pend[0][2] = 1; t_en[1][2] = 1;
      settle("R3 empty");
      check_one("R3 explicit", 0, 0, int'(a_id[9:0]), a_req[0], 1023, 0);
   endtask

   task automatic t_mask_edge();
      @(negedge clk); clear_state();
      make_cand(0, 11, 8'h50);
      t_mask[0] = 8'h50;
      settle("R4 mask equal");
      check_one("R4 explicit equal", 0, 0, int'(a_id[9:0]), a_req[0], 1023, 0);
      @(negedge clk); t_mask[0] = 8'h51;
      settle("R4 mask above");
   endtask

   task automatic t_running();
      @(negedge clk); clear_state();
      make_cand(1, 12, 8'h50);
      t_run[1] = 9'h050;
      settle("R5 run equal");
      check_one("R5 explicit id shown", 0, 1, int'(a_id[19:10]), a_req[1], 12, 0);
      @(negedge clk); t_run[1] = 9'h051;
      settle("R5 run above");
      @(negedge clk); t_run[1] = 9'h000;
      settle("R5 run zero");
   endtask

   task automatic t_gate();
      @(negedge clk); clear_state();
      for (int c = 0; c < CA; c++) make_cand(c, c + 1, 8'h20);
      t_cen[1] = 1'b0;
      settle("R6 one cpu off");
      @(negedge clk); t_den = 1'b0;
      settle("R6 distributor off");
      check_one("R6 explicit", 0, 0, int'(a_id[9:0]), a_req[0], 1023, 0);
   endtask

   task automatic t_idle();
      @(negedge clk); clear_state();
      make_cand(0, 30, 8'hFE);
      make_cand(1, 35, 8'hFF);
      settle("R7 idle run");
      check_one("R7 explicit", 0, 0, int'(a_id[9:0]), a_req[0], 30, 1);
   endtask

   task automatic t_latency();
      @(negedge clk); clear_state();
      settle("R8 baseline");
      @(negedge clk); make_cand(0, 2, 8'h01);
      #1;
      check_one("R8 before edge", 0, 0, int'(a_id[9:0]), a_req[0], 1023, 0);
      settle("R8 after edge");
   endtask

   task automatic t_indep();
      @(negedge clk); clear_state();
      make_cand(0, 1, 8'h10);  make_cand(1, 1, 8'h10);
      t_pend[1][1] = 0;
      make_cand(1, 6, 8'h90);
      t_mask[2] = 8'h00;  make_cand(2, 8, 8'h00);
      t_run[3] = 9'h005;  make_cand(3, 50, 8'h05);
      settle("R9 independent cpus");
   endtask

   task automatic t_random();
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         for (int i = 0; i < NA; i++) t_prio[i] = 8'($urandom_range(0, 15) * 16 + $urandom_range(0, 1));
         for (int c = 0; c < CA; c++) begin
            for (int i = 0; i < NA; i++) begin
               t_pend[c][i] = ($urandom_range(0, 3) == 0);
               t_en[c][i]   = ($urandom_range(0, 2) != 0);
            end
            t_mask[c] = 8'($urandom_range(0, 255));
            t_run[c]  = 9'($urandom_range(0, 256));
            t_cen[c]  = ($urandom_range(0, 9) != 0);
         end
         t_den = ($urandom_range(0, 9) != 0);
         settle("R10 random variants");
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_urgency();
      t_tie();
      t_empty();
      t_mask_edge();
      t_running();
      t_gate();
      t_idle();
      t_latency();
      t_indep();
      t_random();
      finish_run();
   end

endmodule